// File: doc/BRIEF.md
# Filtered External Interrupt Controller

This block takes two asynchronous external interrupt pins (active high), brings each into the local clock domain, and turns a qualifying active period into a sticky request flag. Each channel can run its pin through a persistence filter. The filter counts clock cycles while the synchronised pin stays high and accepts the request only once the run reaches a programmed threshold of up to 20 bits. When the filter is off, a rising edge alone is enough. The single clock is the crystal-oscillator clock that the filter counts.

Software sees three words through a plain write/read port. Select 0 is the control/status word, which holds the per-channel enable and status bits. Select 1 is the filter word of channel 0 and select 2 is the filter word of channel 1. A status bit stays set until software writes a 1 to it. The interrupt output of a channel is high while its enable and its status are both 1.

Each channel holds a small state machine. The states are:
- `FLT_IDLE`: the pin is inactive and the count is zero.
- `FLT_COUNT`: the pin is active and the threshold has not yet been reached.
- `FLT_FIRED`: the request has been raised for this run.

The transitions are:
- IDLE→COUNT: the pin is active and the threshold is not reached.
- IDLE→FIRED and COUNT→FIRED: the pin is active and the threshold is reached, or the filter is off. The set pulse is issued on this transition.
- COUNT→IDLE and FIRED→IDLE: the pin is inactive. The count clears.
- COUNT→COUNT: the pin stays active and the count advances.
- FIRED→FIRED: the pin stays active. The count is held.

Top module: `ext_irq_filter`

## Requirements
- R1: After reset the control/status word (select 0) reads 0. Each filter word (selects 1 and 2) reads 0x0000FFFF, which means threshold 0xFFFF with the filter off.
- R2: A pin change written before clock edge k can set status no earlier than edge k+2, because of the two-flop synchroniser. With the filter off, status reads 1 after edge k+2 and still reads 0 after edge k+1.
- R3: With the filter on and threshold N≥1, status is set after N consecutive synchronised active cycles. For a pin raised before edge k, status is visible after edge k+1+N and not before.
- R4: A single synchronised inactive cycle clears the filter count. A run that is interrupted restarts from zero.
- R5: A status bit is set at most once per uninterrupted active run. After it is cleared while the pin is still held high, it stays 0 until the pin goes low and rises again.
- R6: With the filter off (filter word bit 20 = 0), a rising edge of the synchronised pin sets the status bit.
- R7: A write to select 0 clears status bit i (bit 0 = channel 0, bit 1 = channel 1) where the data bit is 1. A 0 leaves that bit unchanged. A write never sets a status bit.
- R8: If a set event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_out[i]` is 1 exactly while enable bit i and status bit i are both 1. The enable for channel 0 is bit 2 and the enable for channel 1 is bit 3 of the control/status word.
- R10: Filter word i+1 holds the threshold in bits 19:0 and the filter enable in bit 20. Its other bits read 0. Bits 31:4 of the control/status word read 0, and select 3 reads 0.
- R11: A threshold of 0 behaves like 1: with the filter on, status sets on the first synchronised active cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all state and the filter count use it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 2 | Raw external interrupt pins, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 2 | Word written: 0 control/status, 1 filter ch0, 2 filter ch1 |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Word read, same encoding as `wr_sel` |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |
| irq_out | output | 2 | Per-channel interrupt, enable AND status |

## Verification
The bound checker watches four things on every cycle, wherever they arise:
- A status bit falls only after a write-1 to it.
- A status bit rises only when the synchronised pin was high one cycle earlier.
- A set pulse never repeats in the following cycle.
- A set coinciding with a clear always leaves the bit set.

The exact latency through the synchroniser, the threshold count, the restart after a glitch, the reset values and the register field layout are shown only by the bench's directed scenarios. Those scenarios are backed by its per-cycle reference model of status, enables, interrupts and readback.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Per-channel persistence filter states
    typedef enum logic [1:0] {
        FLT_IDLE  = 2'd0,
        FLT_COUNT = 2'd1,
        FLT_FIRED = 2'd2
    } flt_state_e;

    // Select code of the control/status word
    localparam int unsigned CTRL_SEL = 0;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(STAGES); k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < int'(STAGES); k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
    import ext_irq_pkg::*;
#(
    parameter int unsigned THR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             flt_on,
    input  logic [THR_W-1:0] thr,
    output logic             set_pulse
);

    localparam int unsigned CW = THR_W + 1;

    flt_state_e       state_q, state_d;
    logic [THR_W-1:0] cnt_q, cnt_d;
    logic             reached;

    // Threshold test on the count this cycle would reach; bypass always qualifies
    always_comb reached = !flt_on || (({1'b0, cnt_q} + CW'(1)) >= {1'b0, thr});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FLT_IDLE, FLT_COUNT: begin
                if (!act) begin
                    state_d = FLT_IDLE;
                    cnt_d   = '0;
                end else if (reached) begin
                    state_d = FLT_FIRED;
                end else begin
                    state_d = FLT_COUNT;
                    cnt_d   = cnt_q + THR_W'(1);
                end
            end
            FLT_FIRED: begin
                if (!act) begin
                    state_d = FLT_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = FLT_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // One set pulse on entry to FIRED
    always_comb set_pulse = act && (state_q != FLT_FIRED) && reached;

endmodule

// File: rtl/ext_irq_filter.sv
module ext_irq_filter
    import ext_irq_pkg::*;
#(
    parameter int unsigned NCH     = 2,
    parameter int unsigned THR_W   = 20,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SYNC_N  = 2,
    parameter int unsigned THR_RST = 'hFFFF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCH-1:0]                pin_in,
    input  logic                          wr_en,
    input  logic [$clog2(NCH+1)-1:0]      wr_sel,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [$clog2(NCH+1)-1:0]      rd_sel,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NCH-1:0]                irq_out
);

    localparam int unsigned SEL_W = $clog2(NCH + 1);
    localparam int unsigned FEN_B = THR_W;

    logic [NCH-1:0]             sync_q;
    logic [NCH-1:0]             set_ev;
    logic [NCH-1:0]             stat_q;
    logic [NCH-1:0]             en_q;
    logic [NCH-1:0][THR_W-1:0]  thr_q;
    logic [NCH-1:0]             fen_q;
    logic                       wr_ctrl;
    logic                       unused_wr_hi;

    assign wr_ctrl      = wr_en && (wr_sel == SEL_W'(CTRL_SEL));
    assign unused_wr_hi = ^wr_data[DATA_W-1:THR_W+1];

    ext_irq_sync #(.W(NCH), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_q)
    );

    for (genvar i = 0; i < int'(NCH); i++) begin : g_ch
        ext_irq_chan #(.THR_W(THR_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .act       (sync_q[i]),
            .flt_on    (fen_q[i]),
            .thr       (thr_q[i]),
            .set_pulse (set_ev[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                thr_q[i] <= THR_W'(THR_RST);
                fen_q[i] <= 1'b0;
            end else if (wr_en && (wr_sel == SEL_W'(i + 1))) begin
                thr_q[i] <= wr_data[THR_W-1:0];
                fen_q[i] <= wr_data[FEN_B];
            end
        end
    end

    // Status: write-1 clear, set event has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~(wr_ctrl ? wr_data[NCH-1:0] : '0)) | set_ev;
            if (wr_ctrl) en_q <= wr_data[2*NCH-1:NCH];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_W'(CTRL_SEL)) rd_data[2*NCH-1:0] = {en_q, stat_q};
        for (int i = 0; i < int'(NCH); i++) begin
            if (rd_sel == SEL_W'(i + 1)) rd_data[FEN_B:0] = {fen_q[i], thr_q[i]};
        end
    end

    assign irq_out = en_q & stat_q;

endmodule

// File: rtl/ext_irq_filter_chk.sv
module ext_irq_filter_chk #(
    parameter int unsigned NCH = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [$clog2(NCH+1)-1:0] wr_sel,
    input logic [NCH-1:0]           wr_lo,
    input logic [NCH-1:0]           sync_q,
    input logic [NCH-1:0]           set_ev,
    input logic [NCH-1:0]           stat_q
);

    for (genvar i = 0; i < int'(NCH); i++) begin : g_a
        AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stat_q[i]) |-> $past(wr_en && (wr_sel == '0) && wr_lo[i])); // R7
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (set_ev[i] && wr_en && (wr_sel == '0) && wr_lo[i]) |=> stat_q[i]); // R8
        AST_ONE_SET_PER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> !set_ev[i]); // R5
        AST_SET_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_q[i]) |-> $past(sync_q[i])); // R2
    end

endmodule

bind ext_irq_filter ext_irq_filter_chk #(.NCH(NCH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_lo  (wr_data[NCH-1:0]),
    .sync_q (sync_q),
    .set_ev (set_ev),
    .stat_q (stat_q)
);

// File: tb/test_ext_irq_filter.sv
`timescale 1ns/100ps
module test_ext_irq_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin = 2'b00;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [1:0]  irq_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ext_irq_filter i_ext_irq_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .irq_out (irq_out)
    );

    // Behavioural reference model
    bit [1:0] m_s1 = '0, m_s2 = '0, m_st = '0, m_en = '0, m_fen = '0, m_fired = '0;
    int       m_thr [2] = '{32'hFFFF, 32'hFFFF};
    int       m_cnt [2] = '{0, 0};
    bit [1:0] m_set, m_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_st = '0; m_en = '0; m_fen = '0; m_fired = '0;
            m_thr[0] = 32'hFFFF; m_thr[1] = 32'hFFFF; m_cnt[0] = 0; m_cnt[1] = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                m_set[i] = m_s2[i] && !m_fired[i] && (!m_fen[i] || (m_cnt[i] + 1) >= m_thr[i]);
                if (!m_s2[i]) begin m_cnt[i] = 0; m_fired[i] = 1'b0; end
                else if (m_set[i]) m_fired[i] = 1'b1;
                else if (!m_fired[i]) m_cnt[i]++;
            end
            m_clr = (wr_en && wr_sel == 2'd0) ? wr_data[1:0] : 2'b00;
            m_st  = (m_st & ~m_clr) | m_set;
            if (wr_en && wr_sel == 2'd0) m_en = wr_data[3:2];
            for (int i = 0; i < 2; i++) begin
                if (wr_en && wr_sel == 2'(i + 1)) begin
                    m_thr[i] = int'(wr_data[19:0]);
                    m_fen[i] = wr_data[20];
                end
            end
            m_s2 = m_s1;
            m_s1 = pin;
        end
    end

    function automatic logic [31:0] m_read(input logic [1:0] sel);
        case (sel)
            2'd0:    return {28'b0, m_en, m_st};
            2'd1:    return {11'b0, m_fen[0], m_thr[0][19:0]};
            2'd2:    return {11'b0, m_fen[1], m_thr[1][19:0]};
            default: return 32'b0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check(irq_out == (m_en & m_st), "R9 per-cycle irq", {30'b0, irq_out}, {30'b0, m_en & m_st});
            check(rd_data == m_read(rd_sel), "R10 per-cycle readback", rd_data, m_read(rd_sel));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset values
        rd_sel = 2'd0; #0.5;
        check(rd_data == 32'h0, "R1 ctrl reset", rd_data, 32'h0);
        rd_sel = 2'd1; #0.5;
        check(rd_data == 32'h0000FFFF, "R1 filter0 reset", rd_data, 32'h0000FFFF);
        rd_sel = 2'd2; #0.5;
        check(rd_data == 32'h0000FFFF, "R1 filter1 reset", rd_data, 32'h0000FFFF);
        check(irq_out == 2'b00, "R1 irq reset", {30'b0, irq_out}, 32'h0);
        rd_sel = 2'd0;
        step(1);

        wr(2'd0, 32'hC);
        check(rd_data == 32'hC, "R10 enables read back", rd_data, 32'hC);

        // R6 / R2 bypass rising edge on channel 0
        pin[0] = 1'b1;
        step(2);
        check(rd_data[0] == 1'b0, "R2 no set before sync", {31'b0, rd_data[0]}, 32'h0);
        step(1);
        check(rd_data[0] == 1'b1, "R6 bypass edge sets status", {31'b0, rd_data[0]}, 32'h1);
        check(irq_out == 2'b01, "R9 irq follows status", {30'b0, irq_out}, 32'h1);

        // R7 write 0 keeps, write 1 clears
        wr(2'd0, 32'hC);
        check(rd_data[0] == 1'b1, "R7 write 0 keeps status", {31'b0, rd_data[0]}, 32'h1);
        wr(2'd0, 32'hD);
        check(rd_data[0] == 1'b0, "R7 write 1 clears status", {31'b0, rd_data[0]}, 32'h0);
        step(5);
        check(rd_data[0] == 1'b0, "R5 bypass no refire while held", {31'b0, rd_data[0]}, 32'h0);
        pin[0] = 1'b0;
        step(4);

        // R3 filtered channel 1, threshold 5
        wr(2'd2, 32'h0010_0005);
        pin[1] = 1'b1;
        step(6);
        check(rd_data[1] == 1'b0, "R3 not before threshold", {31'b0, rd_data[1]}, 32'h0);
        step(1);
        check(rd_data[1] == 1'b1, "R3 set at threshold", {31'b0, rd_data[1]}, 32'h1);

        // R4 interrupted run restarts
        pin[1] = 1'b0;
        step(3);
        wr(2'd0, 32'hE);
        check(rd_data[1] == 1'b0, "R7 clear ch1", {31'b0, rd_data[1]}, 32'h0);
        pin[1] = 1'b1;
        step(3);
        pin[1] = 1'b0;
        step(1);
        pin[1] = 1'b1;
        step(6);
        check(rd_data[1] == 1'b0, "R4 glitch restarts count", {31'b0, rd_data[1]}, 32'h0);
        step(1);
        check(rd_data[1] == 1'b1, "R4 full run after glitch", {31'b0, rd_data[1]}, 32'h1);

        // R5 filtered: cleared while held stays clear
        wr(2'd0, 32'hE);
        step(8);
        check(rd_data[1] == 1'b0, "R5 filtered no second set", {31'b0, rd_data[1]}, 32'h0);
        pin[1] = 1'b0;
        step(3);

        // R8 set and clear in the same cycle
        pin[0] = 1'b1;
        step(2);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'hD;
        @(negedge clk);
        wr_en = 1'b0;
        check(rd_data[0] == 1'b1, "R8 set beats clear", {31'b0, rd_data[0]}, 32'h1);

        // R11 threshold zero
        pin[0] = 1'b0;
        step(3);
        wr(2'd1, 32'h0010_0000);
        wr(2'd0, 32'hD);
        pin[0] = 1'b1;
        step(2);
        check(rd_data[0] == 1'b0, "R11 not before sync", {31'b0, rd_data[0]}, 32'h0);
        step(1);
        check(rd_data[0] == 1'b1, "R11 threshold zero first cycle", {31'b0, rd_data[0]}, 32'h1);

        // R9 masking by enable
        wr(2'd0, 32'h0);
        check(irq_out == 2'b00, "R9 masked irq", {30'b0, irq_out}, 32'h0);
        check(rd_data[1:0] == 2'b01, "R9 status kept when masked", {30'b0, rd_data[1:0]}, 32'h1);
        wr(2'd0, 32'h4);
        check(irq_out == 2'b01, "R9 unmasked irq", {30'b0, irq_out}, 32'h1);

        // R10 field layout
        wr(2'd2, 32'hFFFF_FFFF);
        rd_sel = 2'd2; #0.5;
        check(rd_data == 32'h001F_FFFF, "R10 filter word width", rd_data, 32'h001F_FFFF);
        rd_sel = 2'd3; #0.5;
        check(rd_data == 32'h0, "R10 unused select", rd_data, 32'h0);
        rd_sel = 2'd0;
        pin = 2'b00;
        step(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule